// File: doc/BRIEF.md
# Mailbox request sequencer

This block is the host side of a command mailbox. It carries out whole mailbox transactions over a single-word register access port that uses a request/acknowledge handshake. A user starts an operation with a one-cycle `start`, giving an operation, a dword address, a word count of 1 to 16 and up to sixteen write words. The four operations are block read, block write, authenticate and power cycle. The sequencer then issues every register access the operation needs, in order. It polls the command word until the far side clears its go bit, spacing the polls by a fixed gap, and gives up when a timeout budget runs out. It then reads the status word and reports a mapped result code, together with any fetched read data.

The mailbox sits at three offsets on the access port: a data window of up to sixteen words starting at `DATA_OFS`, the command word at `CMD_OFS` and the status word at `STAT_OFS`. The access port has two error indications. An access timeout that answers a poll is retried after the gap. Any other error acknowledgement ends the transaction at once. All timeouts are counted in clock cycles and set by parameters.

The controller is a single state machine with these states:
- `S_IDLE`: waits for `start`. A block write then goes to `S_WDATA`; every other operation goes to `S_WCMD`.
- `S_WDATA`: writes the data words one at a time. After the last one it goes to `S_WCMD`.
- `S_WCMD`: writes the command word, then goes to `S_POLL`.
- `S_POLL`: reads the command word. Go bit clear leads to `S_RSTAT`. Go bit set, or an access timeout, leads to `S_GAP`.
- `S_GAP`: waits out the poll spacing. It then returns to `S_POLL`, or goes to `S_FIN` with a timeout result if the budget is spent.
- `S_RSTAT`: reads the status word. A block read whose status is success goes to `S_RDATA`; every other case goes to `S_FIN`.
- `S_RDATA`: fetches the data words, then goes to `S_FIN`.
- `S_FIN`: presents the result for one cycle, then returns to `S_IDLE`.

From every access state, an error acknowledgement goes straight to `S_FIN`.

Top module: `mbox_seq`

## Requirements
- R1: After reset `busy`, `done` and `acc_req` are 0.
- R2: The command word carries a wire opcode in bits 31:28, the dword address in bits 23:2 and the go bit (bit 0) set. The opcode is 0 for block write, 1 for authenticate, 2 for block read and 4 for power cycle. Authenticate and power cycle carry zero address and count, which gives 0x10000001 and 0x40000001. The user `op` input encodes read=0, write=1, authenticate=2, power cycle=3.
- R3: The count field sits in bits 27:24. A read encodes a count of 16 as 0 and any smaller count as itself. A write encodes the count minus one.
- R4: On a block write, bit 1 of the command word is set exactly when the dword address is greater than or equal to `HDR_ADDR`. It is clear for every other operation.
- R5: A block write first writes data word i to offset `DATA_OFS`+i for i in ascending order, and only then writes the command word.
- R6: A block read writes the command, polls, and reads the status. Only if the status is success does it then read offsets `DATA_OFS`+i in ascending order into word i of `rd_data`. A failing status fetches no data.
- R7: Polls are reads of `CMD_OFS`. Each poll is held until acknowledged, and two consecutive polls are separated by at least `GAP_CYC` cycles with no request.
- R8: A poll answered with an access timeout (`acc_tmo`) is retried after the gap and does not end the transaction.
- R9: The result is taken from status bits 3:0: 0 gives OK (0), 1 gives INVAL (1), 2 gives DENIED (2) and any other value gives IO (3).
- R10: Block read and block write use the `LONG_TMO` budget; authenticate and power cycle use `SHORT_TMO`. When the budget runs out the result is TIMEOUT (4), the status word is not read, and `done` comes no earlier than the budget and no later than the budget + `GAP_CYC` + 20 cycles after `start`.
- R11: An error acknowledgement (`acc_err`), or an access timeout on any access other than a poll, ends the transaction with LINK (5) and issues no further access.
- R12: `busy` is high from the cycle after an accepted `start` through the single cycle in which `done` pulses, and low afterwards. A `start` raised while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| op | input | 2 | Operation: read 0, write 1, authenticate 2, power cycle 3 |
| dw_addr | input | AW (22) | Target dword address |
| count | input | CW (5) | Word count, 1 to MAXW |
| wr_data | input | MAXW x 32 | Write words, word i in slice i |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle result strobe |
| result | output | 3 | Result code: OK 0, INVAL 1, DENIED 2, IO 3, TIMEOUT 4, LINK 5 |
| rd_data | output | MAXW x 32 | Fetched read words |
| acc_req | output | 1 | Register access request, held until acknowledged |
| acc_we | output | 1 | Access is a write |
| acc_addr | output | OW (8) | Register offset |
| acc_wdata | output | 32 | Write word |
| acc_ack | input | 1 | Access acknowledge |
| acc_err | input | 1 | Acknowledge carries an error |
| acc_tmo | input | 1 | Acknowledge carries an access timeout |
| acc_rdata | input | 32 | Read word, valid with the acknowledge |

## Verification
Most internal faults show up on the access port within one access. A corrupted index or a wrong state ordering produces an access to a wrong offset, a data word out of sequence, or a command issued before its data. A wrong command field shows as soon as the first command write is acknowledged. A fault in the poll gap or the timeout counter shows at the next poll, in the spacing between requests, or in the cycle at which `done` arrives against the budget window. A wrong result mapping is visible on `result` in the `done` cycle.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    typedef enum logic [1:0] {
        UOP_READ  = 2'd0,
        UOP_WRITE = 2'd1,
        UOP_AUTH  = 2'd2,
        UOP_PCYC  = 2'd3
    } uop_e;

    typedef enum logic [2:0] {
        RES_OK      = 3'd0,
        RES_INVAL   = 3'd1,
        RES_DENIED  = 3'd2,
        RES_IO      = 3'd3,
        RES_TIMEOUT = 3'd4,
        RES_LINK    = 3'd5
    } res_e;

    typedef enum logic [2:0] {
        S_IDLE, S_WDATA, S_WCMD, S_POLL, S_GAP, S_RSTAT, S_RDATA, S_FIN
    } st_e;

    // opcodes decoded by the far side of the mailbox
    localparam logic [3:0] WOP_WRITE = 4'h0;
    localparam logic [3:0] WOP_AUTH  = 4'h1;
    localparam logic [3:0] WOP_READ  = 4'h2;
    localparam logic [3:0] WOP_PCYC  = 4'h4;

endpackage

// File: rtl/mbox_cmd_pack.sv
module mbox_cmd_pack
    import mbox_pkg::*;
#(
    parameter int             AW       = 22,
    parameter int             CW       = 5,
    parameter logic [AW-1:0]  HDR_ADDR = 22'h3F000
) (
    input  uop_e            op,
    input  logic [AW-1:0]   addr,
    input  logic [CW-1:0]   cnt,
    output logic [31:0]     word
);

    always_comb begin
        word    = '0;
        word[0] = 1'b1;
        unique case (op)
            UOP_READ: begin
                word[31:28] = WOP_READ;
                word[27:24] = (cnt >= CW'(16)) ? 4'h0 : cnt[3:0];
                word[2 +: AW] = addr;
            end
            UOP_WRITE: begin
                word[31:28] = WOP_WRITE;
                word[27:24] = 4'(cnt - CW'(1));
                word[2 +: AW] = addr;
                word[1] = (addr >= HDR_ADDR);
            end
            UOP_AUTH: word[31:28] = WOP_AUTH;
            UOP_PCYC: word[31:28] = WOP_PCYC;
            default:  word[31:28] = WOP_AUTH;
        endcase
    end

endmodule

// File: rtl/mbox_res_map.sv
module mbox_res_map
    import mbox_pkg::*;
(
    input  logic [3:0] code,
    output res_e       res
);

    always_comb begin
        unique case (code)
            4'd0:    res = RES_OK;
            4'd1:    res = RES_INVAL;
            4'd2:    res = RES_DENIED;
            default: res = RES_IO;
        endcase
    end

endmodule

// File: rtl/mbox_timer.sv
module mbox_timer #(
    parameter int LONG_TMO  = 500_000_000,
    parameter int SHORT_TMO = 15_000_000,
    parameter int GAP_CYC   = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic long_sel,
    input  logic gap_en,
    output logic hit,
    output logic gap_done
);

    localparam int TMAX = (LONG_TMO > SHORT_TMO) ? LONG_TMO : SHORT_TMO;
    localparam int TW   = $clog2(TMAX + 1);
    localparam int GW   = $clog2(GAP_CYC + 1);

    logic [TW-1:0] elapsed;
    logic [TW-1:0] limit;
    logic [GW-1:0] gap_cnt;

    assign limit    = long_sel ? TW'(LONG_TMO) : TW'(SHORT_TMO);
    assign hit      = (elapsed >= limit);
    assign gap_done = gap_en && (gap_cnt == GW'(GAP_CYC - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            elapsed <= '0;
            gap_cnt <= '0;
        end else begin
            if (!run)      elapsed <= '0;
            else if (!hit) elapsed <= elapsed + TW'(1);
            if (!gap_en)   gap_cnt <= '0;
            else           gap_cnt <= gap_cnt + GW'(1);
        end
    end

endmodule

// File: rtl/mbox_seq.sv
module mbox_seq
    import mbox_pkg::*;
#(
    parameter int             MAXW      = 16,
    parameter int             AW        = 22,
    parameter int             OW        = 8,
    parameter int             DATA_OFS  = 1,
    parameter int             CMD_OFS   = 17,
    parameter int             STAT_OFS  = 18,
    parameter logic [AW-1:0]  HDR_ADDR  = 22'h3F000,
    parameter int             LONG_TMO  = 500_000_000,
    parameter int             SHORT_TMO = 15_000_000,
    parameter int             GAP_CYC   = 5000,
    localparam int            CW        = $clog2(MAXW + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [1:0]             op,
    input  logic [AW-1:0]          dw_addr,
    input  logic [CW-1:0]          count,
    input  logic [MAXW-1:0][31:0]  wr_data,
    output logic                   busy,
    output logic                   done,
    output logic [2:0]             result,
    output logic [MAXW-1:0][31:0]  rd_data,
    output logic                   acc_req,
    output logic                   acc_we,
    output logic [OW-1:0]          acc_addr,
    output logic [31:0]            acc_wdata,
    input  logic                   acc_ack,
    input  logic                   acc_err,
    input  logic                   acc_tmo,
    input  logic [31:0]            acc_rdata
);

    localparam int IW = $clog2(MAXW);

    st_e                   state, state_d;
    uop_e                  op_q;
    logic [AW-1:0]         addr_q;
    logic [CW-1:0]         cnt_q;
    logic [CW-1:0]         idx;
    logic [MAXW-1:0][31:0] wbuf;
    logic [MAXW-1:0][31:0] rbuf;
    res_e                  res_q, res_d, stat_res;
    logic [31:0]           cmd_word;
    logic                  acc_ok, acc_bad, last_word;
    logic                  tmo_hit, gap_done;

    mbox_cmd_pack #(.AW(AW), .CW(CW), .HDR_ADDR(HDR_ADDR)) u_pack (
        .op(op_q), .addr(addr_q), .cnt(cnt_q), .word(cmd_word)
    );

    mbox_res_map u_map (.code(acc_rdata[3:0]), .res(stat_res));

    mbox_timer #(.LONG_TMO(LONG_TMO), .SHORT_TMO(SHORT_TMO), .GAP_CYC(GAP_CYC)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (state == S_POLL || state == S_GAP),
        .long_sel (op_q == UOP_READ || op_q == UOP_WRITE),
        .gap_en   (state == S_GAP),
        .hit      (tmo_hit),
        .gap_done (gap_done)
    );

    assign acc_ok    = acc_ack && !acc_err && !acc_tmo;
    assign acc_bad   = acc_ack && (acc_err || acc_tmo);
    assign last_word = (idx == cnt_q - CW'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_d;
    end

    // captured request, word index, read buffer, result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= UOP_READ;
            addr_q <= '0;
            cnt_q  <= '0;
            idx    <= '0;
            wbuf   <= '0;
            rbuf   <= '0;
            res_q  <= RES_OK;
        end else begin
            if (state == S_IDLE && start) begin
                op_q   <= uop_e'(op);
                addr_q <= dw_addr;
                cnt_q  <= count;
                wbuf   <= wr_data;
                idx    <= '0;
            end
            if (acc_ok && (state == S_WDATA || state == S_RDATA))
                idx <= idx + CW'(1);
            if (acc_ok && state == S_RDATA)
                rbuf[idx[IW-1:0]] <= acc_rdata;
            if (state_d == S_FIN && state != S_FIN)
                res_q <= res_d;
        end
    end

    // next state and result
    always_comb begin
        state_d = state;
        res_d   = RES_OK;
        unique case (state)
            S_IDLE:
                if (start) state_d = (uop_e'(op) == UOP_WRITE) ? S_WDATA : S_WCMD;
            S_WDATA:
                if (acc_bad) begin
                    state_d = S_FIN;
                    res_d   = RES_LINK;
                end else if (acc_ok && last_word) begin
                    state_d = S_WCMD;
                end
            S_WCMD:
                if (acc_bad) begin
                    state_d = S_FIN;
                    res_d   = RES_LINK;
                end else if (acc_ok) begin
                    state_d = S_POLL;
                end
            S_POLL:
                if (acc_ack) begin
                    if (acc_err) begin
                        state_d = S_FIN;
                        res_d   = RES_LINK;
                    end else if (acc_tmo || acc_rdata[0]) begin
                        state_d = S_GAP;
                    end else begin
                        state_d = S_RSTAT;
                    end
                end
            S_GAP:
                if (gap_done) begin
                    state_d = tmo_hit ? S_FIN : S_POLL;
                    res_d   = RES_TIMEOUT;
                end
            S_RSTAT:
                if (acc_bad) begin
                    state_d = S_FIN;
                    res_d   = RES_LINK;
                end else if (acc_ok) begin
                    if (stat_res != RES_OK) begin
                        state_d = S_FIN;
                        res_d   = stat_res;
                    end else begin
                        state_d = (op_q == UOP_READ) ? S_RDATA : S_FIN;
                    end
                end
            S_RDATA:
                if (acc_bad) begin
                    state_d = S_FIN;
                    res_d   = RES_LINK;
                end else if (acc_ok && last_word) begin
                    state_d = S_FIN;
                end
            S_FIN:   state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy      = (state != S_IDLE);
        done      = (state == S_FIN);
        result    = res_q;
        rd_data   = rbuf;
        acc_req   = 1'b0;
        acc_we    = 1'b0;
        acc_addr  = OW'(CMD_OFS);
        acc_wdata = cmd_word;
        unique case (state)
            S_WDATA: begin
                acc_req   = 1'b1;
                acc_we    = 1'b1;
                acc_addr  = OW'(DATA_OFS) + OW'(idx);
                acc_wdata = wbuf[idx[IW-1:0]];
            end
            S_WCMD: begin
                acc_req = 1'b1;
                acc_we  = 1'b1;
            end
            S_POLL:  acc_req = 1'b1;
            S_RSTAT: begin
                acc_req  = 1'b1;
                acc_addr = OW'(STAT_OFS);
            end
            S_RDATA: begin
                acc_req  = 1'b1;
                acc_addr = OW'(DATA_OFS) + OW'(idx);
            end
            default: acc_req = 1'b0;
        endcase
    end

endmodule

// File: rtl/mbox_seq_chk.sv
module mbox_seq_chk #(
    parameter int OW      = 8,
    parameter int CMD_OFS = 17
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          acc_req,
    input logic          acc_we,
    input logic          acc_ack,
    input logic [OW-1:0] acc_addr,
    input logic [31:0]   acc_wdata
);

    a_r12_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r12_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    a_r12_start_accepted: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    a_r1_req_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req |-> busy);

    a_r7_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && !acc_ack) |=> (acc_req && $stable(acc_addr) && $stable(acc_we)));

    a_r2_cmd_go_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && acc_we && acc_addr == OW'(CMD_OFS)) |-> acc_wdata[0]);

endmodule

bind mbox_seq mbox_seq_chk #(.OW(OW), .CMD_OFS(CMD_OFS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .acc_req   (acc_req),
    .acc_we    (acc_we),
    .acc_ack   (acc_ack),
    .acc_addr  (acc_addr),
    .acc_wdata (acc_wdata)
);

// File: tb/mbox_seq_tb.sv
module mbox_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_OFS   = 1;
    localparam int CMD_OFS    = 17;
    localparam int STAT_OFS   = 18;
    localparam int LONG_TMO   = 400;
    localparam int SHORT_TMO  = 60;
    localparam int GAP_CYC    = 8;
    localparam logic [21:0] HDR = 22'h3F000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic             start = 1'b0;
    logic [1:0]       op = 2'd0;
    logic [21:0]      dw_addr = '0;
    logic [4:0]       count = 5'd1;
    logic [15:0][31:0] wr_data = '0;
    logic             busy, done;
    logic [2:0]       result;
    logic [15:0][31:0] rd_data;
    logic             acc_req, acc_we;
    logic [7:0]       acc_addr;
    logic [31:0]      acc_wdata;
    logic             acc_ack = 1'b0, acc_err = 1'b0, acc_tmo = 1'b0;
    logic [31:0]      acc_rdata = '0;

    mbox_seq #(
        .DATA_OFS(DATA_OFS), .CMD_OFS(CMD_OFS), .STAT_OFS(STAT_OFS), .HDR_ADDR(HDR),
        .LONG_TMO(LONG_TMO), .SHORT_TMO(SHORT_TMO), .GAP_CYC(GAP_CYC)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .dw_addr(dw_addr),
        .count(count), .wr_data(wr_data), .busy(busy), .done(done), .result(result),
        .rd_data(rd_data), .acc_req(acc_req), .acc_we(acc_we), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .acc_ack(acc_ack), .acc_err(acc_err), .acc_tmo(acc_tmo),
        .acc_rdata(acc_rdata)
    );

    int n_checks = 0;
    int n_err = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // far-side model
    logic [31:0] dev_data [16];
    logic [31:0] dev_status = '0;
    logic [31:0] last_cmd = '0;
    int busy_polls = 0, tmo_poll = -1, err_acc = -1;
    int poll_no = 0, last_poll = -1, min_gap = 1000000;
    logic        log_we   [64];
    logic [7:0]  log_addr [64];
    logic [31:0] log_wd   [64];
    int n_acc = 0;

    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && acc_req) begin
                if (n_acc < 64) begin
                    log_we[n_acc] = acc_we; log_addr[n_acc] = acc_addr; log_wd[n_acc] = acc_wdata;
                end
                acc_rdata = '0;
                if (n_acc == err_acc) begin
                    acc_err = 1'b1;
                end else if (!acc_we && acc_addr == 8'(CMD_OFS)) begin
                    if (last_poll >= 0 && (cyc - last_poll) < min_gap) min_gap = cyc - last_poll;
                    last_poll = cyc;
                    poll_no++;
                    if (poll_no == tmo_poll) acc_tmo = 1'b1;
                    else begin
                        acc_rdata = {last_cmd[31:1], (busy_polls != 0)};
                        if (busy_polls > 0) busy_polls--;
                    end
                end else if (!acc_we && acc_addr == 8'(STAT_OFS)) begin
                    acc_rdata = dev_status;
                end else if (!acc_we) begin
                    acc_rdata = dev_data[int'(acc_addr) - DATA_OFS];
                end else if (acc_addr == 8'(CMD_OFS)) begin
                    last_cmd = acc_wdata;
                end else begin
                    dev_data[int'(acc_addr) - DATA_OFS] = acc_wdata;
                end
                n_acc++;
                acc_ack = 1'b1;
                @(negedge clk);
                acc_ack = 1'b0; acc_err = 1'b0; acc_tmo = 1'b0;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] cmdw(input int o, input logic [21:0] a, input int c);
        case (o)
            0: cmdw = {4'h2, (c == 16) ? 4'h0 : 4'(c), a, 1'b0, 1'b1};
            1: cmdw = {4'h0, 4'(c - 1), a, (a >= HDR), 1'b1};
            2: cmdw = 32'h1000_0001;
            default: cmdw = 32'h4000_0001;
        endcase
    endfunction

    task automatic prep(input logic [31:0] st, input int bp, input int tp, input int ea);
        dev_status = st; busy_polls = bp; tmo_poll = tp; err_acc = ea;
        n_acc = 0; poll_no = 0; last_poll = -1; min_gap = 1000000;
    endtask

    task automatic run_op(input int o, input logic [21:0] a, input int c, input bit extra,
                          output int cycles);
        int bad_busy = 0;
        @(negedge clk);
        op = 2'(o); dw_addr = a; count = 5'(c); start = 1'b1;
        @(negedge clk);
        start = 1'b0; cycles = 1;
        while (done !== 1'b1) begin
            if (busy !== 1'b1) bad_busy++;
            if (extra && cycles == 4) begin op = 2'd2; start = 1'b1; end
            else start = 1'b0;
            @(negedge clk);
            cycles++;
        end
        start = 1'b0;
        chk(bad_busy == 0, "R12 busy gaps", 32'(bad_busy), 0);
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R12 done one cycle then idle", {busy, done}, 0);
    endtask

    task automatic t_reset();
        chk(busy == 1'b0 && done == 1'b0 && acc_req == 1'b0, "R1 reset outputs",
            {busy, done, acc_req}, 0);
    endtask

    task automatic t_read_basic();
        int cy;
        for (int i = 0; i < 16; i++) dev_data[i] = 32'hD000_0000 + 32'(i) * 32'h101;
        prep(0, 2, -1, -1);
        run_op(0, 22'h123, 4, 0, cy);
        chk(log_we[0] && log_addr[0] == 8'(CMD_OFS), "R6 command first", {log_we[0], log_addr[0]}, CMD_OFS);
        chk(log_wd[0] == cmdw(0, 22'h123, 4), "R2 R3 read command word", log_wd[0], cmdw(0, 22'h123, 4));
        chk(n_acc == 9, "R6 read access count", n_acc, 9);
        chk(!log_we[4] && log_addr[4] == 8'(STAT_OFS), "R6 status after polls", log_addr[4], STAT_OFS);
        for (int i = 0; i < 4; i++) begin
            chk(!log_we[5+i] && log_addr[5+i] == 8'(DATA_OFS + i), "R6 data offset order", log_addr[5+i], DATA_OFS + i);
            chk(rd_data[i] == dev_data[i], "R6 read word", rd_data[i], dev_data[i]);
        end
        chk(result == 3'd0, "R9 success code", result, 0);
        chk(min_gap >= GAP_CYC + 1, "R7 poll spacing", min_gap, GAP_CYC + 1);
    endtask

    task automatic t_read_full();
        int cy;
        for (int i = 0; i < 16; i++) dev_data[i] = 32'h5A00_0000 ^ (32'(i) << 8);
        prep(0, 0, -1, -1);
        run_op(0, 22'h2_0000, 16, 0, cy);
        chk(log_wd[0][27:24] == 4'h0, "R3 read count 16 as 0", log_wd[0][27:24], 0);
        chk(n_acc == 19, "R6 sixteen data reads", n_acc, 19);
        chk(rd_data[15] == dev_data[15], "R6 last read word", rd_data[15], dev_data[15]);
    endtask

    task automatic t_write_low();
        int cy;
        for (int i = 0; i < 16; i++) wr_data[i] = 32'hA000_0000 + 32'(i);
        prep(0, 1, -1, -1);
        run_op(1, 22'h3EFFF, 3, 0, cy);
        for (int i = 0; i < 3; i++)
            chk(log_we[i] && log_addr[i] == 8'(DATA_OFS + i) && log_wd[i] == wr_data[i],
                "R5 data written first in order", log_wd[i], wr_data[i]);
        chk(log_we[3] && log_addr[3] == 8'(CMD_OFS), "R5 command after data", log_addr[3], CMD_OFS);
        chk(log_wd[3] == cmdw(1, 22'h3EFFF, 3), "R3 R4 write below threshold", log_wd[3], cmdw(1, 22'h3EFFF, 3));
        chk(result == 3'd0, "R9 write ok", result, 0);
    endtask

    task automatic t_write_hdr();
        int cy;
        prep(0, 0, -1, -1);
        run_op(1, HDR, 16, 0, cy);
        chk(log_we[16] && log_addr[16] == 8'(CMD_OFS), "R5 command after 16 words", log_addr[16], CMD_OFS);
        chk(log_wd[16][1] == 1'b1 && log_wd[16][27:24] == 4'hF, "R4 R3 header flag at threshold",
            log_wd[16], cmdw(1, HDR, 16));
    endtask

    task automatic t_auth_pcyc();
        int cy;
        prep(1, 0, -1, -1);
        run_op(2, 22'h1FF, 5, 0, cy);
        chk(log_wd[0] == 32'h1000_0001, "R2 authenticate command", log_wd[0], 32'h1000_0001);
        chk(result == 3'd1, "R9 status 1 to INVAL", result, 1);
        prep(2, 1, -1, -1);
        run_op(3, 22'h1FF, 5, 0, cy);
        chk(log_wd[0] == 32'h4000_0001, "R2 power cycle command", log_wd[0], 32'h4000_0001);
        chk(result == 3'd2, "R9 status 2 to DENIED", result, 2);
    endtask

    task automatic t_read_fail();
        int cy;
        prep(7, 0, -1, -1);
        run_op(0, 22'h10, 4, 0, cy);
        chk(result == 3'd3, "R9 other status to IO", result, 3);
        chk(n_acc == 3, "R6 no data fetch on failing status", n_acc, 3);
    endtask

    task automatic t_timeouts();
        int cy;
        prep(0, -1, -1, -1);
        run_op(2, 22'h0, 1, 0, cy);
        chk(result == 3'd4, "R10 short budget timeout code", result, 4);
        chk(cy >= SHORT_TMO && cy <= SHORT_TMO + GAP_CYC + 20, "R10 short budget window", cy, SHORT_TMO);
        chk(log_addr[n_acc-1] == 8'(CMD_OFS) && !log_we[n_acc-1], "R10 no status read on timeout",
            log_addr[n_acc-1], CMD_OFS);
        prep(0, 15, -1, -1);
        run_op(0, 22'h40, 1, 0, cy);
        chk(result == 3'd0 && cy > SHORT_TMO, "R10 read uses long budget", result, 0);
        prep(0, -1, -1, -1);
        run_op(0, 22'h40, 1, 0, cy);
        chk(result == 3'd4, "R10 long budget timeout code", result, 4);
        chk(cy >= LONG_TMO && cy <= LONG_TMO + GAP_CYC + 20, "R10 long budget window", cy, LONG_TMO);
    endtask

    task automatic t_poll_retry();
        int cy;
        prep(0, 3, 2, -1);
        run_op(0, 22'h80, 1, 0, cy);
        chk(result == 3'd0, "R8 poll timeout retried", result, 0);
        chk(n_acc == 8, "R8 access count with retry", n_acc, 8);
    endtask

    task automatic t_link_err();
        int cy;
        prep(0, 0, -1, 1);
        run_op(1, 22'h80, 4, 0, cy);
        chk(result == 3'd5, "R11 error ack gives LINK", result, 5);
        repeat (5) @(negedge clk);
        chk(n_acc == 2 && acc_req == 1'b0, "R11 no access after error", n_acc, 2);
    endtask

    task automatic t_start_busy();
        int cy;
        prep(0, 1, -1, -1);
        run_op(0, 22'h44, 2, 1, cy);
        chk(log_wd[0] == cmdw(0, 22'h44, 2), "R12 first request kept", log_wd[0], cmdw(0, 22'h44, 2));
        repeat (6) @(negedge clk);
        chk(busy == 1'b0 && n_acc == 6, "R12 start while busy ignored", n_acc, 6);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) dev_data[i] = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_basic();
        t_read_full();
        t_write_low();
        t_write_hdr();
        t_auth_pcyc();
        t_read_fail();
        t_timeouts();
        t_poll_retry();
        t_link_err();
        t_start_busy();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL R12 watchdog act=running exp=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule